// File: doc/BRIEF.md
# SPI Register Port with Checksum

This block is a serial register-access slave for a peripheral inside a larger chip. A host drives four pins: an active-low select, a data input, a serial clock and a data output. Every transfer opens with an 8-bit command byte that names a register and says whether it is read or written. The register payload follows, and an optional 8-bit checksum ends the transfer. A small register file sits behind the port. It holds a status byte, an interface-mode word, a 24-bit scratch register and a 32-bit read-only identifier.

A mode field picks the checksum scheme. The scheme can be off, a CRC-8 with polynomial x^8+x^2+x+1, or a bytewise XOR. The XOR option applies to reads only, and writes always use the CRC. If a write carries a bad checksum, the target register is left alone and a sticky error bit is set. Framing is kept by counting bits, so the port also works with select tied low. A run of 64 ones on the data input restores every register and the framing to their power-on state.

The serial pins are sampled on the system clock `clk`. They must already be synchronous to it, and the serial clock must stay in each level for at least three `clk` cycles. There is no streaming data path at the block's edge, so all pins are plain, with no valid/ready and no back-pressure.

Top module: `spi_regport`

## Requirements
- R1: Bits move MSB first. The input is sampled on the rising edge of the serial clock, and the output changes after the falling edge. In the command byte, bit 6 set means read and bit 6 clear means write, bits 5:0 give the address, and bit 7 is ignored.
- R2: Payload length and access are fixed per address. Address 0 is status (8 bits, read-only). Address 1 is mode (16 bits, read/write). Address 2 is scratch (24 bits, read/write). Address 3 is the identifier (32 bits, read-only). Every other address is 8 bits, reads as zero, and drops writes.
- R3: Mode bits 1:0 select the checksum. 00 means none, 01 and 11 mean CRC in both directions, and 10 means XOR on reads and CRC on writes. The setting is taken when a command byte completes.
- R4: The CRC uses polynomial 0x07, starts at zero, takes no final inversion, and runs MSB first over the command byte and the payload. On a read, the 8 CRC bits follow the payload on the output.
- R5: In XOR mode, the read checksum is the XOR of the command byte with every payload byte.
- R6: A write whose received checksum differs from the CRC of its command and payload changes no register and sets status bit 0.
- R7: Status bit 0 stays set until a status read. That read returns 1, and the next status read returns 0.
- R8: 64 consecutive ones sampled while selected restore all registers to their reset values and return framing to the command byte. A run of 63 resets nothing.
- R9: Deasserting select aborts the transfer without a write, returns framing to the command byte and drives the output high.
- R10: With select held low, transfers follow each other back to back, framed only by bit counts.
- R11: The output is high whenever no read payload or read checksum is being shifted out.
- R12: After reset, status is 0, mode is 0, scratch is 0 and the identifier equals ID_VALUE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host, high when idle |

## Verification
The bench builds the port with the default resync length of 64 and a fixed identifier word. The identifier gives a full 32-bit read payload, and with it a 40-bit checksum span. Because the length is 64, a 63-ones run followed by a select pulse can be set against a full 64-ones run. All four checksum codes are applied, and corrupted write checksums are sent in both CRC and XOR mode.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 32;
  localparam int WIN_W  = 24;
  localparam int SUM_W  = 8;
  localparam int CNT_W  = 6;

  localparam logic [ADDR_W-1:0] A_STAT = 6'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 6'd1;
  localparam logic [ADDR_W-1:0] A_SCR  = 6'd2;
  localparam logic [ADDR_W-1:0] A_ID   = 6'd3;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_SUM} phase_t;

  function automatic logic [CNT_W-1:0] pay_len(input logic [ADDR_W-1:0] a);
    case (a)
      A_STAT:  return 6'd8;
      A_MODE:  return 6'd16;
      A_SCR:   return 6'd24;
      A_ID:    return 6'd32;
      default: return 6'd8;
    endcase
  endfunction
endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic rise,
  output logic fall,
  output logic sel,
  output logic din_s
);
  logic r_sclk, r_sclk_d, r_cs_n, r_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_sclk   <= 1'b0;
      r_sclk_d <= 1'b0;
      r_cs_n   <= 1'b1;
      r_din    <= 1'b0;
    end else begin
      r_sclk   <= sclk;
      r_sclk_d <= r_sclk;
      r_cs_n   <= cs_n;
      r_din    <= din;
    end
  end

  assign sel   = ~r_cs_n;
  assign rise  = sel & r_sclk & ~r_sclk_d;
  assign fall  = sel & ~r_sclk & r_sclk_d;
  assign din_s = r_din;

  // R1
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise);
endmodule

// File: rtl/spi_rp_cksum.sv
module spi_rp_cksum #(
  parameter bit          XOR_MODE = 1'b0,
  parameter logic [7:0]  POLY     = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic       bit_in,
  input  logic [2:0] pos,
  output logic [7:0] sum,
  output logic [7:0] nxt
);
  generate
    if (XOR_MODE) begin : g_xor
      assign nxt = sum ^ ({7'b0, bit_in} << (3'd7 - pos));
    end else begin : g_crc
      logic fb;
      assign fb  = sum[7] ^ bit_in;
      assign nxt = {sum[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum <= '0;
    else if (clr)  sum <= '0;
    else if (step) sum <= nxt;
  end

  // R4
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(sum));
endmodule

// File: rtl/spi_rp_regs.sv
module spi_rp_regs
  import spi_rp_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_VALUE = 32'h5EC0_71D3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIN_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              stat_clr,
  input  logic              err_set,
  output logic [WORD_W-1:0] rd_word,
  output logic [1:0]        ckmode
);
  logic [15:0]      mode_q;
  logic [WIN_W-1:0] scr_q;
  logic             err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      scr_q  <= '0;
      err_q  <= 1'b0;
    end else if (soft_rst) begin
      mode_q <= '0;
      scr_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_MODE) mode_q <= wr_data[15:0];
      if (wr_en && wr_addr == A_SCR)  scr_q  <= wr_data;
      if (err_set)       err_q <= 1'b1;
      else if (stat_clr) err_q <= 1'b0;
    end
  end

  // read word is left-aligned so the shifter always starts at bit 31
  always_comb begin
    case (rd_addr)
      A_STAT:  rd_word = {7'b0, err_q, 24'b0};
      A_MODE:  rd_word = {mode_q, 16'b0};
      A_SCR:   rd_word = {scr_q, 8'b0};
      A_ID:    rd_word = ID_VALUE;
      default: rd_word = '0;
    endcase
  end

  assign ckmode = mode_q[1:0];

  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set && !soft_rst) |=> err_q);
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !stat_clr && !soft_rst) |=> err_q);
  // R8
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode_q == '0 && scr_q == '0 && !err_q));
  // R6
  no_bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set && !soft_rst) |=> $stable(scr_q) && $stable(mode_q));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_rp_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_VALUE   = 32'h5EC0_71D3,
  parameter int                RESYNC_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic dout
);
  localparam int OW = $clog2(RESYNC_LEN + 1);

  logic rise, fall, sel, din_s;
  phase_t phase;
  logic [CNT_W-1:0]  cnt, plen;
  logic [CMD_W-1:0]  cmd_sr, cmd_full;
  logic [ADDR_W-1:0] addr;
  logic              is_rd, ck_on, ck_xor;
  logic [WIN_W-1:0]  wsr;
  logic [WORD_W-1:0] rsr, rd_word;
  logic [SUM_W-1:0]  rxsum, crc_sum, crc_nxt, xor_sum, xor_nxt, sel_nxt;
  logic [OW-1:0]     ones;
  logic              dout_r;
  logic [1:0]        ckmode;
  logic              resync, cks_step, cks_clr, cur_bit;
  logic              last_data, nock_done, sum_done, sum_ok;
  logic              wr_en, err_set, stat_clr;
  logic [WIN_W-1:0]  wr_data;

  spi_rp_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .rise(rise), .fall(fall), .sel(sel), .din_s(din_s)
  );

  assign cmd_full  = {cmd_sr[6:0], din_s};
  assign resync    = rise && din_s && (ones == OW'(RESYNC_LEN - 1));
  assign cur_bit   = (phase == PH_DATA && is_rd) ? dout_r : din_s;
  assign cks_step  = rise && !resync && (phase == PH_CMD || phase == PH_DATA);
  assign last_data = rise && !resync && phase == PH_DATA && cnt == plen - 6'd1;
  assign nock_done = last_data && !ck_on;
  assign sum_done  = rise && !resync && phase == PH_SUM && cnt == 6'd7;
  assign cks_clr   = !sel || resync || nock_done || sum_done;
  assign sum_ok    = {rxsum[6:0], din_s} == crc_sum;
  assign wr_en     = !is_rd && (nock_done || (sum_done && sum_ok));
  assign err_set   = !is_rd && sum_done && !sum_ok;
  assign wr_data   = ck_on ? wsr : {wsr[WIN_W-2:0], din_s};
  assign stat_clr  = rise && !resync && phase == PH_CMD && cnt == 6'd7 &&
                     cmd_full[6] && cmd_full[5:0] == A_STAT;
  assign sel_nxt   = ck_xor ? xor_nxt : crc_nxt;

  spi_rp_cksum #(.XOR_MODE(1'b0), .POLY(8'h07)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(cks_clr), .step(cks_step),
    .bit_in(cur_bit), .pos(cnt[2:0]), .sum(crc_sum), .nxt(crc_nxt)
  );

  spi_rp_cksum #(.XOR_MODE(1'b1), .POLY(8'h07)) u_xor (
    .clk(clk), .rst_n(rst_n), .clr(cks_clr), .step(cks_step),
    .bit_in(cur_bit), .pos(cnt[2:0]), .sum(xor_sum), .nxt(xor_nxt)
  );

  spi_rp_regs #(.ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(resync),
    .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data),
    .rd_addr(cmd_full[5:0]), .stat_clr(stat_clr), .err_set(err_set),
    .rd_word(rd_word), .ckmode(ckmode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      cnt    <= '0;
      plen   <= 6'd8;
      cmd_sr <= '0;
      addr   <= '0;
      is_rd  <= 1'b0;
      ck_on  <= 1'b0;
      ck_xor <= 1'b0;
      wsr    <= '0;
      rsr    <= '0;
      rxsum  <= '0;
      ones   <= '0;
      dout_r <= 1'b1;
    end else if (!sel) begin
      phase  <= PH_CMD;
      cnt    <= '0;
      ones   <= '0;
      dout_r <= 1'b1;
    end else begin
      if (rise) begin
        if (resync) begin
          ones  <= '0;
          phase <= PH_CMD;
          cnt   <= '0;
        end else begin
          ones <= din_s ? ones + 1'b1 : '0;
          case (phase)
            PH_CMD: begin
              cmd_sr <= cmd_full;
              if (cnt == 6'd7) begin
                is_rd  <= cmd_full[6];
                addr   <= cmd_full[5:0];
                plen   <= pay_len(cmd_full[5:0]);
                ck_on  <= ckmode != 2'b00;
                ck_xor <= cmd_full[6] && ckmode == 2'b10;
                rsr    <= rd_word;
                phase  <= PH_DATA;
                cnt    <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_DATA: begin
              wsr <= {wsr[WIN_W-2:0], din_s};
              if (cnt == plen - 6'd1) begin
                cnt <= '0;
                if (ck_on) begin
                  phase      <= PH_SUM;
                  rsr[31:24] <= sel_nxt;
                end else begin
                  phase <= PH_CMD;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: begin
              rxsum <= {rxsum[6:0], din_s};
              if (cnt == 6'd7) begin
                phase <= PH_CMD;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          endcase
        end
      end
      if (fall) begin
        if (is_rd && phase != PH_CMD) begin
          dout_r <= rsr[WORD_W-1];
          rsr    <= {rsr[WORD_W-2:0], 1'b0};
        end else begin
          dout_r <= 1'b1;
        end
      end
    end
  end

  assign dout = dout_r;

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (phase == PH_CMD && dout_r));
  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) ? (cnt < plen) : (cnt < 6'd8));
  // R3
  mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_CMD && $past(phase) != PH_CMD) |-> $stable(ck_on) && $stable(ck_xor));
  // R11
  out_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && (phase == PH_CMD || !is_rd)) |=> dout);
endmodule

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
  localparam logic [31:0] M_ID = 32'hC3A5_0F96;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic dout;
  int nvec = 0, nbad = 0;
  bit done = 0;

  logic [15:0] m_mode;
  logic [23:0] m_scr;
  logic        m_err;

  always #4 clk = ~clk;

  spi_regport #(.ID_VALUE(M_ID), .RESYNC_LEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout)
  );

  function automatic int mw(input int a);
    case (a)
      0: return 8;  1: return 16;  2: return 24;  3: return 32;
      default: return 8;
    endcase
  endfunction

  function automatic logic [31:0] mval(input int a);
    case (a)
      0: return {31'b0, m_err};
      1: return {16'b0, m_mode};
      2: return {8'b0, m_scr};
      3: return M_ID;
      default: return 32'b0;
    endcase
  endfunction

  function automatic logic [7:0] crc_of(input logic [39:0] v, input int nb);
    logic [7:0] c = 8'h00;
    for (int i = nb - 1; i >= 0; i--) begin
      logic t = c[7] ^ v[i];
      c = c << 1;
      if (t) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic logic [7:0] xor_of(input logic [39:0] v, input int nb);
    logic [7:0] x = 8'h00;
    for (int k = 0; k < nb / 8; k++) x = x ^ v[8*k +: 8];
    return x;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  task automatic clkn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic d, input logic chk, input logic exp, input string rq);
    sclk = 1'b0;
    din  = d;
    clkn(4);
    if (chk) begin
      nvec++;
      if (dout !== exp) begin
        nbad++;
        $display("FAIL %s: dout=%b expected %b", rq, dout, exp);
      end
    end
    sclk = 1'b1;
    clkn(4);
  endtask

  task automatic wr(input int a, input logic [31:0] v, input logic bad, input string rq);
    int n = mw(a);
    int nb = 8 + n;
    logic [39:0] f = ({32'b0, 2'b00, 6'(a)} << n) | (40'(v) & ((40'd1 << n) - 1));
    logic ckon = m_mode[1:0] != 2'b00;
    logic [7:0] s = crc_of(f, nb) ^ {7'b0, bad};
    for (int i = nb - 1; i >= 0; i--) bitx(f[i], 1'b1, 1'b1, rq);
    if (ckon) for (int i = 7; i >= 0; i--) bitx(s[i], 1'b1, 1'b1, rq);
    if (!ckon || !bad) begin
      if (a == 1) m_mode = v[15:0];
      if (a == 2) m_scr  = v[23:0];
    end else begin
      m_err = 1'b1;
    end
  endtask

  task automatic rd(input int a, input string rq);
    int n = mw(a);
    int nb = 8 + n;
    logic [31:0] val = mval(a);
    logic [39:0] f = ({32'b0, 2'b01, 6'(a)} << n) | 40'(val);
    logic [1:0] md = m_mode[1:0];
    logic [7:0] s = (md == 2'b10) ? xor_of(f, nb) : crc_of(f, nb);
    for (int i = 7; i >= 0; i--) bitx(f[n + i], 1'b1, 1'b1, rq);
    for (int i = n - 1; i >= 0; i--) bitx(1'b0, 1'b1, val[i], rq);
    if (md != 2'b00) for (int i = 7; i >= 0; i--) bitx(1'b0, 1'b1, s[i], rq);
    if (a == 0) m_err = 1'b0;
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) bitx(1'b1, 1'b0, 1'b1, "R8");
    if (n >= 64) begin
      m_mode = '0; m_scr = '0; m_err = 1'b0;
    end
  endtask

  task automatic cs_pulse();
    sclk = 1'b0;
    cs_n = 1'b1;
    clkn(6);
    nvec++;
    if (dout !== 1'b1) begin
      nbad++;
      $display("FAIL R9: dout=%b expected 1 while deselected", dout);
    end
    cs_n = 1'b0;
    clkn(2);
  endtask

  initial begin
    #(200000 * 8);
    nbad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    m_mode = '0; m_scr = '0; m_err = 1'b0;
    clkn(5);
    rst_n = 1'b1;
    clkn(2);
    nvec++;
    if (dout !== 1'b1) begin
      nbad++;
      $display("FAIL R12: dout=%b expected 1 after reset", dout);
    end
    cs_n = 1'b0;
    clkn(4);
    // R12 reset contents
    rd(0, "R12"); rd(1, "R12"); rd(2, "R12"); rd(3, "R12");
    // R2 read-only, unmapped addresses
    rd(9, "R2");
    wr(3, 32'h1234_5678, 1'b0, "R2"); rd(3, "R2");
    wr(0, 32'hFF, 1'b0, "R2");        rd(0, "R2");
    wr(9, 32'h5A, 1'b0, "R2");        rd(9, "R2");
    // R1 / R10 back-to-back with select held low
    wr(2, 32'hA5C31E, 1'b0, "R1"); rd(2, "R10");
    wr(1, 32'h7F00, 1'b0, "R10");  rd(1, "R10");
    // R3 / R4 CRC mode
    wr(1, 32'h0001, 1'b0, "R3");
    rd(2, "R4"); rd(3, "R4");
    wr(2, 32'h3C5A96, 1'b0, "R4"); rd(2, "R4");
    // R6 / R7 corrupted write, sticky flag
    wr(2, 32'h111111, 1'b1, "R6"); rd(2, "R6"); rd(1, "R6");
    rd(0, "R7"); rd(0, "R7");
    // R5 XOR reads, CRC writes
    wr(1, 32'h0002, 1'b0, "R3");
    rd(2, "R5"); rd(3, "R5"); rd(1, "R5");
    wr(2, 32'h0F0F0F, 1'b0, "R5"); rd(2, "R5");
    wr(1, 32'h4402, 1'b1, "R6"); rd(1, "R6"); rd(0, "R7"); rd(0, "R7");
    // R3 code 11 behaves as CRC
    wr(1, 32'h8003, 1'b0, "R3"); rd(2, "R3"); rd(0, "R3");
    // R9 abort mid-write
    cs_pulse();
    for (int i = 7; i >= 0; i--) bitx(i == 1, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 6; i++) bitx(1'b1, 1'b1, 1'b1, "R9");
    cs_pulse();
    rd(2, "R9");
    // R8 63 ones resets nothing, 64 ones restores everything
    wr(2, 32'h00ABCD, 1'b0, "R8");
    cs_pulse();
    ones(63);
    cs_pulse();
    rd(1, "R8"); rd(2, "R8");
    ones(64);
    rd(1, "R8"); rd(2, "R8"); rd(0, "R8");
    wr(2, 32'h654321, 1'b0, "R8"); rd(2, "R8");
    clkn(4);
    summary();
  end
endmodule